// File: doc/BRIEF.md
# Misaligned Word Load Assembler

This block sits between a processor's load port and a data cache that only serves aligned 32-bit words. A load may name a 32-bit value starting at any byte address. A load at an aligned address costs one cache read. A load at any other address costs two reads of consecutive aligned words, which can lie in different cache lines. The block takes the two words and packs the bytes of the requested value into one little-endian 32-bit result.

The two lowest address bits never leave the block. The cache sees only word addresses. The cache side handles one read at a time. A read is presented with a request valid and is taken when the cache raises its ready. Its data comes back later on a separate response-valid strobe. A miss only lengthens that wait, and the block waits as long as it takes. The load side accepts one load at a time. It shows the result for exactly one cycle and then becomes ready again.

Top module: `mlm_top`

## Requirements
- R1: After a synchronous active-high reset, `ld_ready` is 1, `cr_valid` and `res_valid` are 0, and `res_data` reads zero because any captured words are cleared.
- R2: A load whose address has bits [1:0] equal to 0 produces exactly one cache read, at word address `ld_addr[31:2]`.
- R3: A load with a nonzero offset produces exactly two cache reads: first at `ld_addr[31:2]`, then at that word address plus 1. The addition wraps modulo 2^30.
- R4: At most one cache read is outstanding. `cr_valid` stays low from a read's acceptance until its response arrives.
- R5: No result is shown until every read of the load has been answered. Each response may be delayed any number of cycles.
- R6: For offset k (0 to 3), `res_data` equals bits [8k+31:8k] of the 64-bit pair {second word, first word}. For k = 0, this is the first word.
- R7: `res_valid` is high for exactly one cycle, the cycle after the last response. In the following cycle `ld_ready` is 1.
- R8: While `cr_valid` is high and `cr_ready` is low, `cr_valid` stays high and `cr_addr` does not change.
- R9: A `cp_valid` pulse while no read is outstanding is ignored and does not change the result.
- R10: When the first word is the last word of a 128-byte line (word address bits [4:0] all ones), the second read goes to the first word of the next line and the result is still correct.
- R11: While a load is in progress, `ld_ready` is 0, and a `ld_valid` held high during that time starts no new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Block can accept a load |
| ld_addr | input | 32 | Byte address of the load |
| res_valid | output | 1 | Result present (one cycle) |
| res_data | output | 32 | Assembled load value |
| cr_valid | output | 1 | Cache read request present |
| cr_ready | input | 1 | Cache accepts the read |
| cr_addr | output | 30 | Aligned word address of the read |
| cp_valid | input | 1 | Cache response data present |
| cp_data | input | 32 | Cache response word |

## Verification
Two events can fall in the same cycle: the cache accepting a read, and a stray response strobe carrying junk data. The bench provokes this by driving `cp_valid` with inverted data in the very cycle it raises `cr_ready`. A correct block must ignore that strobe and wait for the real response. The result value then shows whether the junk word was wrongly taken. A second overlap comes from holding `ld_valid` high with a different address while a load is in progress. The bench judges it by `ld_ready` staying low and by the number and addresses of the cache reads logged for that load.

// File: rtl/mlm_pkg.sv
package mlm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE        = 3'd0,
      ST_READ_FIRST  = 3'd1,
      ST_WAIT_FIRST  = 3'd2,
      ST_READ_SECOND = 3'd3,
      ST_WAIT_SECOND = 3'd4,
      ST_DONE        = 3'd5
   } mlm_state_e;

endpackage

// File: rtl/mlm_addr_split.sv
module mlm_addr_split #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 2,
   localparam int WA_W  = ADDR_W - OFF_W
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [WA_W-1:0]   word_first,
   output logic [WA_W-1:0]   word_second,
   output logic [OFF_W-1:0]  byte_off,
   output logic              misaligned
);

   assign word_first  = byte_addr[ADDR_W-1:OFF_W];
   assign byte_off    = byte_addr[OFF_W-1:0];
   // natural wrap of the word counter at the top of the address space
   assign word_second = word_first + WA_W'(1);
   assign misaligned  = |byte_off;

endmodule

// File: rtl/mlm_byte_merge.sv
module mlm_byte_merge #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFF_W = $clog2(BYTES),
   localparam int HI_W  = DATA_W - 8,
   localparam int PAIR_W = DATA_W + HI_W
) (
   input  logic [DATA_W-1:0] lo_word,
   input  logic [HI_W-1:0]   hi_word,
   input  logic [OFF_W-1:0]  byte_off,
   output logic [DATA_W-1:0] merged
);

   logic [PAIR_W-1:0] pair;
   logic [DATA_W-1:0] cand [BYTES];

   assign pair = {hi_word, lo_word};

   for (genvar k = 0; k < BYTES; k++) begin : g_window
      assign cand[k] = pair[8*k +: DATA_W];
   end

   assign merged = cand[byte_off];

endmodule

// File: rtl/mlm_ctrl.sv
module mlm_ctrl
   import mlm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ld_valid,
   input  logic misaligned,
   input  logic cr_ready,
   input  logic cp_valid,
   output logic ld_ready,
   output logic cr_valid,
   output logic sel_second,
   output logic cap_first,
   output logic cap_second,
   output logic res_valid
);

   mlm_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:        if (ld_valid) state_d = ST_READ_FIRST;
         ST_READ_FIRST:  if (cr_ready) state_d = ST_WAIT_FIRST;
         ST_WAIT_FIRST:  if (cp_valid) state_d = misaligned ? ST_READ_SECOND : ST_DONE;
         ST_READ_SECOND: if (cr_ready) state_d = ST_WAIT_SECOND;
         ST_WAIT_SECOND: if (cp_valid) state_d = ST_DONE;
         ST_DONE:        state_d = ST_IDLE;
         default:        state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign ld_ready   = (state_q == ST_IDLE);
   assign cr_valid   = (state_q == ST_READ_FIRST) || (state_q == ST_READ_SECOND);
   assign sel_second = (state_q == ST_READ_SECOND);
   assign cap_first  = (state_q == ST_WAIT_FIRST)  && cp_valid;
   assign cap_second = (state_q == ST_WAIT_SECOND) && cp_valid;
   assign res_valid  = (state_q == ST_DONE);

endmodule

// File: rtl/mlm_top.sv
module mlm_top #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int OFF_W = $clog2(BYTES),
   localparam int WA_W  = ADDR_W - OFF_W,
   localparam int HI_W  = DATA_W - 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              cr_valid,
   input  logic              cr_ready,
   output logic [WA_W-1:0]   cr_addr,
   input  logic              cp_valid,
   input  logic [DATA_W-1:0] cp_data
);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("mlm_top: DATA_W must be a multiple of 8 and at least 16");
   end
   if ((BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("mlm_top: DATA_W/8 must be a power of two");
   end
   if (ADDR_W <= OFF_W + 1) begin : g_bad_addr_w
      $error("mlm_top: ADDR_W too small for the word size");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] word0_q;
   logic [HI_W-1:0]   word1_q;
   logic [WA_W-1:0]   wa_first, wa_second;
   logic [OFF_W-1:0]  off;
   logic              misaligned;
   logic              sel_second, cap_first, cap_second;

   mlm_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_split (
      .byte_addr  (addr_q),
      .word_first (wa_first),
      .word_second(wa_second),
      .byte_off   (off),
      .misaligned (misaligned)
   );

   mlm_ctrl i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .ld_valid  (ld_valid),
      .misaligned(misaligned),
      .cr_ready  (cr_ready),
      .cp_valid  (cp_valid),
      .ld_ready  (ld_ready),
      .cr_valid  (cr_valid),
      .sel_second(sel_second),
      .cap_first (cap_first),
      .cap_second(cap_second),
      .res_valid (res_valid)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         word0_q <= '0;
         word1_q <= '0;
      end else begin
         if (ld_valid && ld_ready) addr_q  <= ld_addr;
         if (cap_first)            word0_q <= cp_data;
         if (cap_second)           word1_q <= cp_data[HI_W-1:0];
      end
   end

   assign cr_addr = sel_second ? wa_second : wa_first;

   mlm_byte_merge #(.DATA_W(DATA_W)) i_merge (
      .lo_word (word0_q),
      .hi_word (word1_q),
      .byte_off(off),
      .merged  (res_data)
   );

endmodule

// File: rtl/mlm_checker.sv
module mlm_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int OFF_W = $clog2(DATA_W / 8),
   localparam int WA_W  = ADDR_W - OFF_W
) (
   input logic             clk,
   input logic             rst,
   input logic             ld_valid,
   input logic             ld_ready,
   input logic [OFF_W-1:0] ld_off,
   input logic             res_valid,
   input logic             cr_valid,
   input logic             cr_ready,
   input logic [WA_W-1:0]  cr_addr,
   input logic             cp_valid
);

   logic             outst;
   logic [1:0]       rd_cnt;
   logic [WA_W-1:0]  last_wa;
   logic [OFF_W-1:0] off_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         outst   <= 1'b0;
         rd_cnt  <= '0;
         last_wa <= '0;
         off_q   <= '0;
      end else begin
         if (ld_valid && ld_ready) begin
            rd_cnt <= '0;
            off_q  <= ld_off;
         end
         if (cr_valid && cr_ready) begin
            outst   <= 1'b1;
            rd_cnt  <= rd_cnt + 2'd1;
            last_wa <= cr_addr;
         end else if (cp_valid) begin
            outst <= 1'b0;
         end
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ld_ready && !cr_valid && !res_valid)); // R1
   AST_READ_COUNT: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (rd_cnt == ((off_q == '0) ? 2'd1 : 2'd2))); // R2
   AST_SECOND_NEXT: assert property (@(posedge clk) disable iff (rst)
      (cr_valid && cr_ready && rd_cnt == 2'd1) |-> (cr_addr == last_wa + WA_W'(1))); // R3
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
      outst |-> !cr_valid); // R4
   AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> ($past(cp_valid) && !outst)); // R5
   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> (!res_valid && ld_ready)); // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cr_valid && !cr_ready) |=> (cr_valid && $stable(cr_addr))); // R8
   AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
      (cr_valid || outst) |-> !ld_ready); // R11

endmodule

bind mlm_top mlm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mlm_checker (
   .clk      (clk),
   .rst      (rst),
   .ld_valid (ld_valid),
   .ld_ready (ld_ready),
   .ld_off   (ld_addr[$clog2(DATA_W/8)-1:0]),
   .res_valid(res_valid),
   .cr_valid (cr_valid),
   .cr_ready (cr_ready),
   .cr_addr  (cr_addr),
   .cp_valid (cp_valid)
);

// File: tb/test_mlm_top.sv
module test_mlm_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_valid = 1'b0;
   logic        ld_ready;
   logic [31:0] ld_addr = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        cr_valid;
   logic        cr_ready = 1'b0;
   logic [29:0] cr_addr;
   logic        cp_valid = 1'b0;
   logic [31:0] cp_data = '0;

   int total = 0;
   int bad = 0;
   int gnt_dly = 0;
   int rsp_dly = 0;
   bit junk = 1'b0;
   int req_n = 0;
   int rsp_n = 0;
   logic [29:0] req_log [4];

   always #5 clk = ~clk;

   mlm_top i_mlm_top (
      .clk(clk), .rst(rst),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .res_valid(res_valid), .res_data(res_data),
      .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_addr(cr_addr),
      .cp_valid(cp_valid), .cp_data(cp_data)
   );

   function automatic logic [31:0] mem_word(input logic [29:0] wa);
      return ({2'b00, wa} * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // cache model: grant after gnt_dly cycles, answer after rsp_dly more
   initial begin
      forever begin
         @(negedge clk);
         if (cr_valid && !rst) begin
            logic [29:0] wa;
            repeat (gnt_dly) @(negedge clk);
            wa = cr_addr;
            cr_ready = 1'b1;
            if (junk) begin
               cp_valid = 1'b1;
               cp_data  = ~mem_word(wa);
            end
            req_log[req_n % 4] = wa;
            req_n++;
            @(negedge clk);
            cr_ready = 1'b0;
            cp_valid = 1'b0;
            repeat (rsp_dly) @(negedge clk);
            cp_valid = 1'b1;
            cp_data  = mem_word(wa);
            rsp_n++;
            @(negedge clk);
            cp_valid = 1'b0;
         end
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(ld_ready === 1'b1, "R1 ld_ready", 64'(ld_ready), 1);
      check(cr_valid === 1'b0, "R1 cr_valid", 64'(cr_valid), 0);
      check(res_valid === 1'b0, "R1 res_valid", 64'(res_valid), 0);
      check(res_data === 32'h0, "R1 res_data", 64'(res_data), 0);
   endtask

   task automatic do_load(input logic [31:0] a, input bit poke);
      int q0, r0, n;
      logic [29:0] wa;
      logic [1:0] off;
      logic [63:0] pair;
      logic [31:0] exp;
      int exp_rd;
      wa = a[31:2];
      off = a[1:0];
      pair = {mem_word(wa + 30'd1), mem_word(wa)};
      exp = pair[8*off +: 32];
      exp_rd = (off == 2'd0) ? 1 : 2;
      q0 = req_n;
      r0 = rsp_n;
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = a;
      @(negedge clk);
      if (poke) ld_addr = ~a;
      else      ld_valid = 1'b0;
      n = 0;
      while (res_valid !== 1'b1 && n < 400) begin
         if (ld_ready !== 1'b0) check(1'b0, "R11 ld_ready busy", 64'(ld_ready), 0);
         @(negedge clk);
         n++;
      end
      ld_valid = 1'b0;
      check(res_valid === 1'b1, "R5 result appears", 64'(res_valid), 1);
      check(rsp_n - r0 == exp_rd, "R5 all responses before result", 64'(rsp_n - r0), 64'(exp_rd));
      check(res_data === exp, "R6 R9 merged value", 64'(res_data), 64'(exp));
      if (off == 2'd0)
         check(req_n - q0 == 1, "R2 single read", 64'(req_n - q0), 1);
      else
         check(req_n - q0 == 2, "R3 two reads", 64'(req_n - q0), 2);
      check(req_log[q0 % 4] === wa, "R2 first word address", 64'(req_log[q0 % 4]), 64'(wa));
      if (off != 2'd0) begin
         if (wa[4:0] == 5'h1f)
            check(req_log[(q0 + 1) % 4] === wa + 30'd1, "R10 next line address",
                  64'(req_log[(q0 + 1) % 4]), 64'(wa + 30'd1));
         else
            check(req_log[(q0 + 1) % 4] === wa + 30'd1, "R3 second word address",
                  64'(req_log[(q0 + 1) % 4]), 64'(wa + 30'd1));
      end
      @(negedge clk);
      check(res_valid === 1'b0, "R7 one-cycle result", 64'(res_valid), 0);
      check(ld_ready === 1'b1, "R7 ready after result", 64'(ld_ready), 1);
      check(req_n - q0 == exp_rd, "R11 no extra load started", 64'(req_n - q0), 64'(exp_rd));
   endtask

   logic [31:0] bases [6];

   initial begin
      bases[0] = 32'h0000_0000;
      bases[1] = 32'h0000_007C;
      bases[2] = 32'h1234_5678;
      bases[3] = 32'h8000_0FFC;
      bases[4] = 32'hFFFF_FFFC;
      bases[5] = 32'h0000_0040;
      do_reset();
      for (int b = 0; b < 6; b++) begin
         for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 3; m++) begin
               gnt_dly = m;
               rsp_dly = 3 * m;
               junk    = (m == 1);
               do_load({bases[b][31:2], 2'b00} + 32'(k), m == 2);
            end
         end
      end
      // long miss latencies on both reads of a line-crossing load
      gnt_dly = 0;
      rsp_dly = 20;
      junk = 1'b1;
      do_load(32'h0000_00FE, 1'b1);
      rsp_dly = 0;
      junk = 1'b0;
      do_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule